// File: doc/BRIEF.md
# SDLC Frame Transmitter with Self-Timed RTS Release

This block serializes bytes into a bit-oriented synchronous frame, one bit for each transmit clock enable pulse. A frame is an opening flag, the payload bytes, a two-byte frame check sequence, and a closing flag. Between frames the line rests in the mark state, a steady 1. Payload and check bits go through zero-bit insertion, so a flag pattern can never appear inside a frame.

The block also drives a request-to-send output. This output turns external line drivers on and off. Software raises the request bit, queues a frame, and may drop the bit at once while the frame is still being shifted out. When the self-timed release mode is in effect, dropping the bit only arms the release. The pin stays active until the transmit clock edge that ends the last bit of the closing flag, and falls on that edge. No further software action is needed to turn the line around. In every other mode the pin follows the request bit on the next enable pulse.

Top module: `sdlc_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `txd` is 1, `rtsActive` is 0 until requested, and `txReady` is 0 outside enable cycles.
- R2: Each frame is sent in this order: the flag 0x7E, the payload bytes, the low check byte, the high check byte, and the flag 0x7E again. Then the line returns to mark on the next enable. Every byte goes out least significant bit first.
- R3: In the payload and check bytes, a 0 is inserted after every run of five consecutive 1s, and the run counter continues across byte boundaries. Flags are never stuffed.
- R4: The check value is computed over the payload bits only, as CRC-16 with generator x^16+x^12+x^5+1. The generator is processed LSB first, as the constant 0x8408. The register is preset to 0xFFFF, and the complement of the final value is sent.
- R5: A payload byte is accepted only on a clock where `txClkEn`, `txValid` and `txReady` are all 1, and `txReady` is never 1 without `txClkEn`. When a byte is accepted with `txEom` set, it is the last payload byte, even if `txValid` stays high.
- R6: If no byte is valid when the next payload byte is due, the check bytes and the closing flag follow the bytes already sent.
- R7: `txd` and `rtsActive` change only on clocks where `txClkEn` is 1.
- R8: When `cfgAutoRelease`=1, `cfgSdlc`=1 and `cfgFlagFill`=0, clearing `rtsReq` during a frame keeps `rtsActive` at 1. It falls on the enable that ends the last closing flag bit, which is the same enable on which `txd` returns to mark.
- R9: If any one of those three configuration conditions does not hold, `rtsActive` takes the value of `rtsReq` on the next enable.
- R10: Clearing `rtsReq` while no frame is in progress drops `rtsActive` on the next enable.
- R11: Setting `rtsReq` again before the closing flag ends cancels the armed release, and `rtsActive` stays 1 past the end of the frame.
- R12: With `rtsReq`=1, `rtsActive` is 1 after the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txClkEn | input | 1 | One-cycle pulse marking a rising transmit clock edge |
| cfgSdlc | input | 1 | Bit-oriented framing mode selected |
| cfgFlagFill | input | 1 | Flag-fill-on-underrun option; when 1, self-timed release is off |
| cfgAutoRelease | input | 1 | Enable for the self-timed RTS release |
| rtsReq | input | 1 | Software request-to-send control bit |
| txData | input | DATA_W | Payload byte |
| txValid | input | 1 | Payload byte is valid |
| txEom | input | 1 | Payload byte is the last of the frame |
| txReady | output | 1 | A byte is taken this cycle if valid |
| txd | output | 1 | Serial line output |
| rtsActive | output | 1 | Request-to-send pin, 1 = active |

## Verification
The assertions assume that `txClkEn` is a single-cycle pulse sampled on `clk`, and that the configuration bits do not change while a frame is on the line, because the release check reads them afresh at every enable. The stimulus changes configuration only between frames, with the line idle. It drives every input just after a falling clock edge, with at least one clock without an enable between pulses. Payload is held on `txValid` until a cycle in which `txReady` is seen, so the handshake assumptions in the properties always hold.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

  localparam logic [7:0] FLAG_OCTET = 8'h7E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS_LO,
    ST_FCS_HI,
    ST_CLOSE
  } txState_e;

  typedef enum logic [1:0] {
    SRC_FLAG,
    SRC_DATA,
    SRC_FCS_LO,
    SRC_FCS_HI
  } loadSrc_e;

  // strobes from the sequencer to the datapath, valid in enable cycles
  typedef struct packed {
    logic     step;       // put the next bit on the line
    logic     load;       // that bit is bit 0 of a freshly loaded octet
    loadSrc_e src;        // which octet to load
    logic     stuff;      // put an inserted zero on the line
    logic     mark;       // put idle mark on the line
    logic     crcInit;    // preset the check register
    logic     crcFeed;    // fold the emitted bit into the check register
    logic     countOnes;  // emitted bit is subject to zero insertion
  } dpCtl_t;

endpackage

// File: rtl/sdlc_tx_dp.sv
module sdlc_tx_dp
  import sdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STUFF_RUN = 5,
  parameter logic [2*DATA_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txClkEn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] txData,
  output logic              txd,
  output logic              stuffDue
);

  localparam int CRC_W = 2 * DATA_W;
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] loadVal;
  logic [CRC_W-1:0]  crc;
  logic [RUN_W-1:0]  onesCnt;
  logic              emitBit;
  logic              crcFb;

  always_comb begin
    case (ctl.src)
      SRC_FLAG:   loadVal = DATA_W'(FLAG_OCTET);
      SRC_DATA:   loadVal = txData;
      SRC_FCS_LO: loadVal = ~crc[DATA_W-1:0];
      default:    loadVal = ~crc[CRC_W-1:DATA_W];
    endcase
  end

  assign emitBit  = ctl.load ? loadVal[0] : shreg[0];
  assign crcFb    = crc[0] ^ emitBit;
  assign stuffDue = (onesCnt == RUN_W'(STUFF_RUN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txd     <= 1'b1;
      shreg   <= '0;
      crc     <= '1;
      onesCnt <= '0;
    end else if (txClkEn) begin
      if (ctl.mark) begin
        txd <= 1'b1;
      end else if (ctl.stuff) begin
        txd <= 1'b0;
      end else if (ctl.step) begin
        txd   <= emitBit;
        shreg <= ctl.load ? (loadVal >> 1) : (shreg >> 1);
      end

      if (ctl.crcInit) begin
        crc <= '1;
      end else if (ctl.crcFeed) begin
        crc <= (crc >> 1) ^ (crcFb ? CRC_POLY : '0);
      end

      if (ctl.step && ctl.countOnes) begin
        onesCnt <= emitBit ? onesCnt + RUN_W'(1) : '0;
      end else begin
        onesCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/sdlc_tx_ctrl.sv
module sdlc_tx_ctrl
  import sdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   txClkEn,
  input  logic   txValid,
  input  logic   txEom,
  input  logic   stuffDue,
  output dpCtl_t ctl,
  output logic   txReady,
  output logic   inFrame,
  output logic   frameEnd
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(1);

  txState_e         st, stNxt;
  logic [CNT_W-1:0] bitCnt, bitNxt;
  logic             lastByte, lastNxt;
  logic             byteDone;

  function automatic dpCtl_t loadCtl(loadSrc_e s, logic feed, logic cnt);
    dpCtl_t c;
    c = '0;
    c.step = 1'b1;
    c.load = 1'b1;
    c.src = s;
    c.crcFeed = feed;
    c.countOnes = cnt;
    return c;
  endfunction

  function automatic dpCtl_t shiftCtl(logic feed, logic cnt);
    dpCtl_t c;
    c = '0;
    c.step = 1'b1;
    c.crcFeed = feed;
    c.countOnes = cnt;
    return c;
  endfunction

  assign byteDone = (bitCnt == BYTE_END);
  assign inFrame  = (st != ST_IDLE);

  always_comb begin
    ctl      = '0;
    stNxt    = st;
    bitNxt   = bitCnt;
    lastNxt  = lastByte;
    txReady  = 1'b0;
    frameEnd = 1'b0;
    if (txClkEn) begin
      case (st)
        ST_IDLE: begin
          if (txValid) begin
            ctl         = loadCtl(SRC_FLAG, 1'b0, 1'b0);
            ctl.crcInit = 1'b1;
            stNxt       = ST_OPEN;
            bitNxt      = FIRST_BIT;
          end else begin
            ctl.mark = 1'b1;
          end
        end
        ST_OPEN: begin
          if (!byteDone) begin
            ctl    = shiftCtl(1'b0, 1'b0);
            bitNxt = bitCnt + 1'b1;
          end else begin
            txReady = 1'b1;
            bitNxt  = FIRST_BIT;
            if (txValid) begin
              ctl     = loadCtl(SRC_DATA, 1'b1, 1'b1);
              stNxt   = ST_DATA;
              lastNxt = txEom;
            end else begin
              ctl   = loadCtl(SRC_FCS_LO, 1'b0, 1'b1);
              stNxt = ST_FCS_LO;
            end
          end
        end
        ST_DATA: begin
          if (stuffDue) begin
            ctl.stuff = 1'b1;
          end else if (!byteDone) begin
            ctl    = shiftCtl(1'b1, 1'b1);
            bitNxt = bitCnt + 1'b1;
          end else begin
            txReady = !lastByte;
            bitNxt  = FIRST_BIT;
            if (!lastByte && txValid) begin
              ctl     = loadCtl(SRC_DATA, 1'b1, 1'b1);
              lastNxt = txEom;
            end else begin
              ctl   = loadCtl(SRC_FCS_LO, 1'b0, 1'b1);
              stNxt = ST_FCS_LO;
            end
          end
        end
        ST_FCS_LO: begin
          if (stuffDue) begin
            ctl.stuff = 1'b1;
          end else if (!byteDone) begin
            ctl    = shiftCtl(1'b0, 1'b1);
            bitNxt = bitCnt + 1'b1;
          end else begin
            ctl    = loadCtl(SRC_FCS_HI, 1'b0, 1'b1);
            stNxt  = ST_FCS_HI;
            bitNxt = FIRST_BIT;
          end
        end
        ST_FCS_HI: begin
          if (stuffDue) begin
            ctl.stuff = 1'b1;
          end else if (!byteDone) begin
            ctl    = shiftCtl(1'b0, 1'b1);
            bitNxt = bitCnt + 1'b1;
          end else begin
            ctl    = loadCtl(SRC_FLAG, 1'b0, 1'b0);
            stNxt  = ST_CLOSE;
            bitNxt = FIRST_BIT;
          end
        end
        ST_CLOSE: begin
          if (!byteDone) begin
            ctl    = shiftCtl(1'b0, 1'b0);
            bitNxt = bitCnt + 1'b1;
          end else begin
            ctl.mark = 1'b1;
            frameEnd = 1'b1;
            stNxt    = ST_IDLE;
            bitNxt   = '0;
            lastNxt  = 1'b0;
          end
        end
        default: begin
          ctl.mark = 1'b1;
          stNxt    = ST_IDLE;
          bitNxt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      bitCnt   <= '0;
      lastByte <= 1'b0;
    end else begin
      st       <= stNxt;
      bitCnt   <= bitNxt;
      lastByte <= lastNxt;
    end
  end

endmodule

// File: rtl/sdlc_rts_release.sv
module sdlc_rts_release (
  input  logic clk,
  input  logic rstN,
  input  logic txClkEn,
  input  logic cfgSdlc,
  input  logic cfgFlagFill,
  input  logic cfgAutoRelease,
  input  logic rtsReq,
  input  logic inFrame,
  input  logic frameEnd,
  output logic rtsActive
);

  logic autoMode;
  logic holdPin;

  // self-timed release only in bit-oriented mode without flag fill
  assign autoMode = cfgAutoRelease & cfgSdlc & ~cfgFlagFill;
  // keep an already active pin while the frame has not finished its flag
  assign holdPin  = autoMode & rtsActive & inFrame & ~frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsActive <= 1'b0;
    end else if (txClkEn) begin
      rtsActive <= rtsReq | holdPin;
    end
  end

endmodule

// File: rtl/sdlc_frame_tx.sv
module sdlc_frame_tx
  import sdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STUFF_RUN = 5,
  parameter logic [2*DATA_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txClkEn,
  input  logic              cfgSdlc,
  input  logic              cfgFlagFill,
  input  logic              cfgAutoRelease,
  input  logic              rtsReq,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              txEom,
  output logic              txReady,
  output logic              txd,
  output logic              rtsActive
);

  dpCtl_t ctlBus;
  logic   stuffDue;
  logic   inFrame;
  logic   frameEnd;

  sdlc_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txClkEn  (txClkEn),
    .txValid  (txValid),
    .txEom    (txEom),
    .stuffDue (stuffDue),
    .ctl      (ctlBus),
    .txReady  (txReady),
    .inFrame  (inFrame),
    .frameEnd (frameEnd)
  );

  sdlc_tx_dp #(
    .DATA_W    (DATA_W),
    .STUFF_RUN (STUFF_RUN),
    .CRC_POLY  (CRC_POLY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .txClkEn  (txClkEn),
    .ctl      (ctlBus),
    .txData   (txData),
    .txd      (txd),
    .stuffDue (stuffDue)
  );

  sdlc_rts_release u_rts (
    .clk            (clk),
    .rstN           (rstN),
    .txClkEn        (txClkEn),
    .cfgSdlc        (cfgSdlc),
    .cfgFlagFill    (cfgFlagFill),
    .cfgAutoRelease (cfgAutoRelease),
    .rtsReq         (rtsReq),
    .inFrame        (inFrame),
    .frameEnd       (frameEnd),
    .rtsActive      (rtsActive)
  );

endmodule

// File: rtl/sdlc_tx_chk.sv
module sdlc_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txClkEn,
  input logic cfgSdlc,
  input logic cfgFlagFill,
  input logic cfgAutoRelease,
  input logic rtsReq,
  input logic txReady,
  input logic txd,
  input logic rtsActive,
  input logic inFrame,
  input logic ctlMark
);

  logic autoOn;
  assign autoOn = cfgAutoRelease && cfgSdlc && !cfgFlagFill;

  p_quiet_between_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    !txClkEn |=> ($stable(txd) && $stable(rtsActive)));

  p_ready_needs_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txClkEn);

  p_req_raises_pin_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txClkEn && rtsReq) |=> rtsActive);

  p_direct_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txClkEn && !rtsReq && !autoOn) |=> !rtsActive);

  p_hold_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txClkEn && autoOn && rtsActive && inFrame && !ctlMark) |=> rtsActive);

  p_release_at_mark_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txClkEn && autoOn && !rtsReq && inFrame && ctlMark) |=> (!rtsActive && txd));

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txClkEn && ctlMark) |=> txd);

endmodule

bind sdlc_frame_tx sdlc_tx_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .txClkEn        (txClkEn),
  .cfgSdlc        (cfgSdlc),
  .cfgFlagFill    (cfgFlagFill),
  .cfgAutoRelease (cfgAutoRelease),
  .rtsReq         (rtsReq),
  .txReady        (txReady),
  .txd            (txd),
  .rtsActive      (rtsActive),
  .inFrame        (inFrame),
  .ctlMark        (ctlBus.mark)
);

// File: tb/sim_sdlc_frame_tx.sv
module sim_sdlc_frame_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txClkEn = 1'b0;
  logic       cfgSdlc = 1'b0;
  logic       cfgFlagFill = 1'b0;
  logic       cfgAutoRelease = 1'b0;
  logic       rtsReq = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txEom = 1'b0;
  logic       txReady;
  logic       txd;
  logic       rtsActive;

  always #4 clk = ~clk;

  sdlc_frame_tx u0 (
    .clk            (clk),
    .rstN           (rstN),
    .txClkEn        (txClkEn),
    .cfgSdlc        (cfgSdlc),
    .cfgFlagFill    (cfgFlagFill),
    .cfgAutoRelease (cfgAutoRelease),
    .rtsReq         (rtsReq),
    .txData         (txData),
    .txValid        (txValid),
    .txEom          (txEom),
    .txReady        (txReady),
    .txd            (txd),
    .rtsActive      (rtsActive)
  );

  typedef struct packed {
    logic [2:0]  nBytes;
    logic [31:0] bytes;   // first byte in bits 7:0
    logic        autoEn;
    logic        sdlc;
    logic        fill;
    logic        useEom;
  } vec_t;

  localparam int NVEC = 6;
  localparam int CLEAR_TICK = 5;
  localparam logic [7:0] FLAG = 8'h7E;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{3'd2, 32'h0000AA55, 1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd3, 32'h00017EFF, 1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd2, 32'h0000F81F, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd1, 32'h0000003C, 1'b1, 1'b0, 1'b0, 1'b1},
    '{3'd2, 32'h00004281, 1'b1, 1'b1, 1'b1, 1'b1},
    '{3'd4, 32'h78563412, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  int   nCmp = 0;
  int   nBad = 0;
  logic [7:0] curBytes [0:3];
  int   curN;
  logic expBits [0:255];
  int   expLen;
  logic capTxd [0:299];
  logic capRts [0:299];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic addBit(input logic b, inout int ones, input bit stuffed);
    expBits[expLen] = b;
    expLen++;
    if (stuffed) begin
      if (b) ones++;
      else ones = 0;
      if (ones == 5) begin
        expBits[expLen] = 1'b0;
        expLen++;
        ones = 0;
      end
    end
  endtask

  task automatic buildExp();
    logic [15:0] crc;
    int ones;
    expLen = 0;
    ones = 0;
    crc = 16'hFFFF;
    for (int i = 0; i < 8; i++) addBit(FLAG[i], ones, 1'b0);
    for (int k = 0; k < curN; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic b;
        logic fb;
        b = curBytes[k][i];
        fb = crc[0] ^ b;
        crc = crc >> 1;
        if (fb) crc = crc ^ 16'h8408;
        addBit(b, ones, 1'b1);
      end
    end
    crc = ~crc;
    for (int i = 0; i < 16; i++) addBit(crc[i], ones, 1'b1);
    ones = 0;
    for (int i = 0; i < 8; i++) addBit(FLAG[i], ones, 1'b0);
  endtask

  // one enable pulse; returns whether a byte was handed over
  task automatic tick(output logic took);
    @(negedge clk);
    txClkEn = 1'b1;
    #1 took = txReady && txValid;
    @(posedge clk);
    @(negedge clk);
    txClkEn = 1'b0;
  endtask

  task automatic runFrame(input logic aEn, input logic sdl, input logic fil,
                          input logic eom, input int clearAt, input int resetAt,
                          input int total);
    logic took;
    int idx;
    cfgAutoRelease = aEn;
    cfgSdlc = sdl;
    cfgFlagFill = fil;
    rtsReq = 1'b1;
    txValid = 1'b0;
    txEom = 1'b0;
    tick(took);
    capRts[0] = rtsActive;
    idx = 0;
    for (int t = 1; t <= total; t++) begin
      txValid = (t <= expLen) && ((idx < curN) || eom);
      txData = (idx < curN) ? curBytes[idx] : 8'hEE;
      txEom = eom && (idx == curN - 1);
      if (t > clearAt) rtsReq = 1'b0;
      if (resetAt > 0 && t > resetAt) rtsReq = 1'b1;
      tick(took);
      if (took) idx++;
      capTxd[t-1] = txd;
      capRts[t] = rtsActive;
    end
    txValid = 1'b0;
    txEom = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    nCmp++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic took;
    int mism;
    int rel;
    bit autoEff;
    string tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    chk(rtsActive == 1'b0, "R1", "rts in reset", int'(rtsActive), 0);
    chk(txReady == 1'b0, "R1", "ready in reset", int'(txReady), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    // table of frames
    for (int v = 0; v < NVEC; v++) begin
      curN = int'(VECS[v].nBytes);
      for (int k = 0; k < 4; k++) curBytes[k] = VECS[v].bytes[8*k +: 8];
      buildExp();
      runFrame(VECS[v].autoEn, VECS[v].sdlc, VECS[v].fill, VECS[v].useEom,
               CLEAR_TICK, -1, expLen + 2);
      mism = 0;
      for (int i = 0; i < expLen; i++) if (capTxd[i] !== expBits[i]) mism++;
      if (capTxd[expLen] !== 1'b1) mism++;
      case (v)
        1: tag = "R2 R3 R4 R5";
        2: tag = "R2 R3 R4";
        5: tag = "R2 R4 R6";
        default: tag = "R2 R4 R5";
      endcase
      chk(mism == 0, tag, $sformatf("vector %0d stream bits wrong", v), mism, 0);

      autoEff = VECS[v].autoEn && VECS[v].sdlc && !VECS[v].fill;
      rel = autoEff ? expLen + 1 : CLEAR_TICK + 1;
      mism = (capRts[0] !== 1'b1) ? 1 : 0;
      for (int t = 1; t <= expLen + 2; t++) if (capRts[t] !== (t < rel)) mism++;
      chk(mism == 0, autoEff ? "R8 R12" : "R9 R12",
          $sformatf("vector %0d rts profile errors", v), mism, 0);
      rtsReq = 1'b0;
      tick(took);
    end

    // cancel of an armed release, then a clear while idle
    curN = 1;
    curBytes[0] = 8'hC3;
    buildExp();
    runFrame(1'b1, 1'b1, 1'b0, 1'b1, 3, 6, expLen + 2);
    mism = 0;
    for (int t = 0; t <= expLen + 2; t++) if (capRts[t] !== 1'b1) mism++;
    chk(mism == 0, "R11", "rts low after re-request", mism, 0);
    rtsReq = 1'b0;
    tick(took);
    chk(rtsActive == 1'b0, "R10", "rts after idle clear", int'(rtsActive), 0);
    chk(txd == 1'b1, "R1", "idle line", int'(txd), 1);

    // no enable: nothing moves, no byte taken
    rtsReq = 1'b1;
    txValid = 1'b1;
    txData = 8'h99;
    repeat (4) @(negedge clk);
    chk(rtsActive == 1'b0, "R7", "rts moved without enable", int'(rtsActive), 0);
    chk(txReady == 1'b0, "R5", "ready without enable", int'(txReady), 0);
    chk(txd == 1'b1, "R7", "txd moved without enable", int'(txd), 1);
    txValid = 1'b0;
    tick(took);
    chk(rtsActive == 1'b1, "R12", "rts after request", int'(rtsActive), 1);
    chk(txd == 1'b1 && !took, "R1", "idle with no data", int'(txd), 1);
    rtsReq = 1'b0;
    tick(took);
    chk(rtsActive == 1'b0, "R10", "rts after clear idle", int'(rtsActive), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule